// File: doc/BRIEF.md
# Streaming Three-Tap Moving Average

This block smooths a stream of unsigned samples. It accepts at most one sample per clock and produces one result for every stream position. A result is the mean of the sample at that position and its two direct neighbours, the one before it and the one after it. A stream opens with a start marker on its first sample, and the stream length is presented in the same cycle. That length lets the block find the last position without any end marker.

The block needs the sample that follows a position before it can finish that position's result. Each result therefore leaves one accepted sample late. Two small tap registers hold the current and the previous sample. The first and last positions lack one neighbour, so they are averaged over the two samples that exist. After the last sample, the final result is pushed out on the next clock without waiting for more input. Idle cycles inside a stream only stretch the timing and do not change any value.

Top module: `tri_tap_avg`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `avg_valid` is 0.
- R2: For an interior position i, where 0 < i < N-1, the output is floor((x[i-1]+x[i]+x[i+1])/3). The sum is formed two bits wider than a sample, so full-scale inputs do not overflow.
- R3: For position 0 of a stream with N >= 2, the output is floor((x[0]+x[1])/2).
- R4: For position N-1 of a stream with N >= 2, the output is floor((x[N-2]+x[N-1])/2).
- R5: When N = 1, the single output equals the single sample.
- R6: The result for position i (i < N-1) appears with `avg_valid` high in the cycle after sample i+1 is accepted. In every other cycle of a stream, including cycles where `smp_valid` is low, `avg_valid` is 0.
- R7: The result for position N-1 appears in the cycle after the last sample is accepted, whatever the inputs are in that cycle.
- R8: A sample with `smp_valid` high and `smp_start` low is ignored when no stream is open, which is the case after the last sample of a stream. It produces no output.
- R9: A sample with `smp_start` high always begins a new stream at position 0, even in the middle of a stream. The abandoned stream produces no further output, and the new start sample produces no output in its own cycle.
- R10: `stream_len` is captured only together with `smp_start`. Its value in any other cycle has no effect. `stream_len` must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_start | input | 1 | The presented sample is position 0 of a new stream |
| smp_data | input | DATA_W | Unsigned sample value |
| stream_len | input | LEN_W | Number of samples N in the stream, read with `smp_start` |
| avg_valid | output | 1 | A result is presented this cycle |
| avg_data | output | DATA_W | Unsigned truncated average |

## Verification
Two cases are the hardest to reach from the ports. The first is a stream cut short by a new start marker, which must leave no trace of the abandoned stream. The second is a flush cycle that coincides with stray valid input arriving after the stream has closed. Directed sequences build both cases explicitly: one stream is cut after three samples, and the flush cycle and the cycle after it carry valid samples without a start marker. Random streams with random lengths, random idle gaps, near-full-scale data and a `stream_len` that changes in the middle of a stream cover the arithmetic and timing paths around them.

// File: rtl/tri_tap_pkg.sv
// Shared types for the three-tap averager.
// Assumes nothing beyond being compiled before its users.
package tri_tap_pkg;
    // Selects which combination of taps forms the result on the next edge.
    typedef enum logic [2:0] {
        EMIT_NONE = 3'd0,   // no result this edge
        EMIT_HEAD = 3'd1,   // position 0: current and next
        EMIT_MID  = 3'd2,   // interior: previous, current and next
        EMIT_TAIL = 3'd3,   // last position: previous and current
        EMIT_SOLO = 3'd4    // stream of one: current only
    } emit_kind_t;
endpackage

// File: rtl/tri_tap_track.sv
// Position tracker: follows the stream position, captures the length on the
// start marker and decides which result, if any, completes on this edge.
// Assumes stream_len >= 1 whenever smp_start is high with smp_valid.
module tri_tap_track
    import tri_tap_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_start,
    input  logic [LEN_W-1:0] stream_len,
    output logic             take,
    output emit_kind_t       kind
);
    logic [LEN_W-1:0] pos_q, len_q, pos_now, len_now;
    logic             open_q, flush_q, solo_q, is_last;

    // Resolve the position and length that apply to this cycle's sample.
    always_comb begin
        take    = smp_valid && (smp_start || open_q);
        pos_now = smp_start ? '0 : pos_q;
        len_now = smp_start ? stream_len : len_q;
        is_last = (pos_now == len_now - LEN_W'(1));
    end

    // Choose the result completed on this edge; a flush takes priority.
    always_comb begin
        kind = EMIT_NONE;
        if (flush_q)
            kind = solo_q ? EMIT_SOLO : EMIT_TAIL;
        else if (take && pos_now != '0)
            kind = (pos_now == LEN_W'(1)) ? EMIT_HEAD : EMIT_MID;
    end

    // Advance the position, open or close the stream, arm the flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            len_q   <= '0;
            open_q  <= 1'b0;
            flush_q <= 1'b0;
            solo_q  <= 1'b0;
        end else begin
            flush_q <= take && is_last;
            solo_q  <= take && is_last && (pos_now == '0);
            if (take) begin
                pos_q  <= pos_now + LEN_W'(1);
                len_q  <= len_now;
                open_q <= !is_last;
            end
        end
    end

    // R10
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_start) |-> (stream_len != '0));
    // R10
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (pos_q < len_q));
    // R5
    solo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        solo_q |-> flush_q);
endmodule

// File: rtl/tri_tap_regs.sv
// Tap registers: hold the current sample and the one before it.
// Assumes the caller asserts take only for accepted samples.
module tri_tap_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] prev_q,
    output logic [DATA_W-1:0] cur_q
);
    // Shift the taps by one on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            cur_q  <= '0;
        end else if (take) begin
            prev_q <= cur_q;
            cur_q  <= smp_data;
        end
    end
endmodule

// File: rtl/tri_tap_mix.sv
// Combiner: forms the truncated mean of the taps chosen by kind.
// Assumes unsigned operands; the sum is two bits wider than a sample.
module tri_tap_mix
    import tri_tap_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  emit_kind_t        kind,
    input  logic [DATA_W-1:0] prev_q,
    input  logic [DATA_W-1:0] cur_q,
    input  logic [DATA_W-1:0] nxt,
    output logic [DATA_W-1:0] avg
);
    localparam int SUM_W = DATA_W + 2;

    logic [SUM_W-1:0] sum3, head2, tail2, quot;

    // Widened sums and the selected quotient.
    always_comb begin
        sum3  = SUM_W'(prev_q) + SUM_W'(cur_q) + SUM_W'(nxt);
        head2 = SUM_W'(cur_q) + SUM_W'(nxt);
        tail2 = SUM_W'(prev_q) + SUM_W'(cur_q);
        case (kind)
            EMIT_MID:  quot = sum3 / SUM_W'(3);
            EMIT_HEAD: quot = head2 >> 1;
            EMIT_TAIL: quot = tail2 >> 1;
            EMIT_SOLO: quot = SUM_W'(cur_q);
            default:   quot = '0;
        endcase
        avg = quot[DATA_W-1:0];
    end
endmodule

// File: rtl/tri_tap_avg.sv
// Top of the three-tap moving average: tracker, tap registers, combiner and
// a registered output stage. One result per stream position, one accepted
// sample late, with the last result flushed on the following clock.
// Assumes at most one sample per cycle and stream_len >= 1 on each start.
module tri_tap_avg
    import tri_tap_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_start,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [LEN_W-1:0]  stream_len,
    output logic              avg_valid,
    output logic [DATA_W-1:0] avg_data
);
    logic              take;
    emit_kind_t        kind;
    logic [DATA_W-1:0] prev_q, cur_q, avg;

    tri_tap_track #(.LEN_W(LEN_W)) i_track (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_start(smp_start), .stream_len(stream_len),
        .take(take), .kind(kind)
    );

    tri_tap_regs #(.DATA_W(DATA_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .take(take), .smp_data(smp_data),
        .prev_q(prev_q), .cur_q(cur_q)
    );

    tri_tap_mix #(.DATA_W(DATA_W)) i_mix (
        .kind(kind), .prev_q(prev_q), .cur_q(cur_q), .nxt(smp_data),
        .avg(avg)
    );

    // Register the result so the output is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_valid <= 1'b0;
            avg_data  <= '0;
        end else begin
            avg_valid <= (kind != EMIT_NONE);
            if (kind != EMIT_NONE)
                avg_data <= avg;
        end
    end

    // R6
    out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> $past(take) || $past(kind == EMIT_TAIL) || $past(kind == EMIT_SOLO));
    // R7
    flush_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EMIT_TAIL || kind == EMIT_SOLO) |=> avg_valid);
    // R9
    start_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_start && kind != EMIT_TAIL && kind != EMIT_SOLO) |=> !avg_valid);
endmodule

// File: tb/test_tri_tap_avg.sv
module test_tri_tap_avg;
    localparam int DW = 16;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic          smp_start = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [LW-1:0] stream_len = '0;
    logic          avg_valid;
    logic [DW-1:0] avg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int unsigned xs [0:63];

    always #5 clk = ~clk;

    tri_tap_avg #(.DATA_W(DW), .LEN_W(LW)) i_tri_tap_avg (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_start(smp_start),
        .smp_data(smp_data), .stream_len(stream_len),
        .avg_valid(avg_valid), .avg_data(avg_data)
    );

    // Expected result for position i of a stream of n held in xs.
    function automatic int unsigned expect_at(int n, int i);
        if (n == 1) return xs[0];
        if (i == 0) return (xs[0] + xs[1]) / 2;
        if (i == n - 1) return (xs[n-2] + xs[n-1]) / 2;
        return (xs[i-1] + xs[i] + xs[i+1]) / 3;
    endfunction

    task automatic check_out(string req, bit ev, int unsigned ed);
        n_chk++;
        if (avg_valid !== ev || (ev && avg_data !== DW'(ed))) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                     req, avg_valid, avg_data, ev, ed);
        end
    endtask

    // Drive one cycle, then sample after the edge has settled.
    task automatic cyc(bit v, bit s, int unsigned d, int unsigned len);
        smp_valid  = v;
        smp_start  = s;
        smp_data   = DW'(d);
        stream_len = LW'(len);
        @(posedge clk);
        #1;
    endtask

    // One stream of n samples with random gaps; optional length noise.
    task automatic run_stream(int n, int gap_pct, bit len_noise, bit big);
        for (int k = 0; k < n; k++)
            xs[k] = big ? (32'hFFFF - ($urandom % 8)) : ($urandom % 65536);
        for (int p = 0; p < n; p++) begin
            if (p > 0) begin
                while (($urandom % 100) < gap_pct) begin
                    cyc(1'b0, 1'b0, $urandom, $urandom % 256);
                    check_out("R6 idle", 1'b0, 0);
                end
            end
            cyc(1'b1, p == 0, xs[p], (p == 0 || !len_noise) ? n : 1 + $urandom % 255);
            if (p == 0)
                check_out("R6 R9 start", 1'b0, 0);
            else if (p == 1)
                check_out(len_noise ? "R3 R10" : "R3", 1'b1, expect_at(n, 0));
            else
                check_out(len_noise ? "R2 R10" : "R2", 1'b1, expect_at(n, p - 1));
        end
        cyc(1'b1, 1'b0, $urandom, $urandom % 256);
        check_out(n == 1 ? "R5 R7" : "R4 R7", 1'b1, expect_at(n, n - 1));
        cyc(1'b1, 1'b0, $urandom, $urandom % 256);
        check_out("R8", 1'b0, 0);
        cyc(1'b0, 1'b0, 0, 0);
        check_out("R8 quiet", 1'b0, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        cyc(1'b1, 1'b1, 5, 3);
        check_out("R1 in reset", 1'b0, 0);
        cyc(1'b0, 1'b0, 0, 0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 7, 2);
        check_out("R1 after reset", 1'b0, 0);
        cyc(1'b0, 1'b0, 0, 0);
        check_out("R8 no stream", 1'b0, 0);

        // Directed: N = 1, N = 2, N = 3, full scale.
        run_stream(1, 0, 1'b0, 1'b0);
        run_stream(2, 0, 1'b0, 1'b0);
        run_stream(3, 30, 1'b0, 1'b0);
        run_stream(6, 0, 1'b0, 1'b1);

        // Directed R9: abandon a stream of 5 after three samples.
        xs[0] = 10; xs[1] = 20; xs[2] = 40;
        cyc(1'b1, 1'b1, xs[0], 5);
        check_out("R9 first", 1'b0, 0);
        cyc(1'b1, 1'b0, xs[1], 5);
        check_out("R9 R3", 1'b1, 15);
        cyc(1'b1, 1'b0, xs[2], 5);
        check_out("R9 R2", 1'b1, 23);
        run_stream(4, 20, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 0, 0);
        check_out("R9 no residue", 1'b0, 0);

        // Random streams with gaps and length noise.
        for (int t = 0; t < 40; t++)
            run_stream(1 + $urandom % 40, $urandom % 50, ($urandom % 2) == 1,
                       ($urandom % 5) == 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule